// File: doc/BRIEF.md
# Clock Gate Control Register Bank

This block holds one 32-bit control register per gated peripheral. Each register carries a 2-bit need level for each power domain. Software reaches every register through four aliased addresses. The direct alias replaces the contents. The set, clear and toggle aliases change only the bits that are 1 in the written mask, so a single write enables or disables a gate without a read-modify-write sequence.

From the stored need levels, the current power mode and the per-domain activity flags, the block computes one registered enable per peripheral. That enable feeds the clock gating cells outside this block. A peripheral's clock is requested when at least one active domain holds a need level that covers the present mode.

Top module: `cgate_bank`

## Requirements
- R1: After reset every register reads 0 and every bit of `gate_en` is 0.
- R2: The address is {gate index, alias[1:0], offset[1:0]}, where the offset bits are ignored. Alias 0 is direct, 1 is set, 2 is clear and 3 is toggle. A direct write replaces the implemented bits. A read through any alias returns the current value of the indexed register.
- R3: A write through the set alias ORs the mask into the register. Bits that are 0 in the mask keep their value.
- R4: A write through the clear alias clears each bit that is 1 in the mask. All other bits keep their value.
- R5: A write through the toggle alias inverts each bit that is 1 in the mask. All other bits keep their value.
- R6: A write whose gate index is NUM_GATES or above changes no register. A read with such an index returns 0.
- R7: Domain d uses bits [2d+1:2d]. Bits at 2*NUM_DOMAINS and above always read 0 and ignore writes.
- R8: Need level codes are: 00 never; 01 in RUN only; 10 in RUN and WAIT; 11 in every mode. `pwr_mode` is 0=RUN, 1=WAIT, 2=STOP. The value 3 is handled like STOP.
- R9: `gate_en[g]` is the OR, over all domains d, of `dom_active[d]` AND (the level of domain d in register g covers the mode).
- R10: A write takes effect at the clock edge where the strobe is sampled. `gate_en` is registered and follows the register contents and inputs one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | IDX_W+4 | {gate index, alias, offset} |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwr_mode | input | 2 | Power mode: 0 RUN, 1 WAIT, 2 STOP |
| dom_active | input | NUM_DOMAINS | Per-domain activity flags |
| gate_en | output | NUM_GATES | Registered clock enable per peripheral |

## Verification
The bench builds the bank with NUM_GATES=5 and IDX_W=3. With those values, indices 5 to 7 are legal addresses that decode to no register, so ignored writes and zero reads can be exercised directly. NUM_DOMAINS stays at 4, so 24 reserved bits of each register are present to test that they stay zero. Random writes through all four aliases are mixed with random modes, including the reserved mode value 3, and with random domain activity patterns.

// File: rtl/cgate_pkg.sv
package cgate_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    ALIAS_DIRECT = 2'd0,
    ALIAS_SET    = 2'd1,
    ALIAS_CLR    = 2'd2,
    ALIAS_TOG    = 2'd3
  } alias_e;

  localparam logic [1:0] MODE_RUN  = 2'd0;
  localparam logic [1:0] MODE_WAIT = 2'd1;
  localparam logic [1:0] MODE_STOP = 2'd2;

  localparam logic [1:0] NEED_NONE    = 2'd0;
  localparam logic [1:0] NEED_RUN     = 2'd1;
  localparam logic [1:0] NEED_RUNWAIT = 2'd2;
  localparam logic [1:0] NEED_ALWAYS  = 2'd3;

  // Does a need level cover the present power mode? Unknown mode acts as STOP.
  function automatic logic need_met(logic [1:0] code, logic [1:0] mode);
    case (code)
      NEED_ALWAYS:  return 1'b1;
      NEED_RUNWAIT: return (mode == MODE_RUN) || (mode == MODE_WAIT);
      NEED_RUN:     return (mode == MODE_RUN);
      default:      return 1'b0;
    endcase
  endfunction

  // Next register value for a write through one alias, limited to implemented bits.
  function automatic logic [DATA_W-1:0] alias_update(logic [DATA_W-1:0] cur,
                                                     logic [DATA_W-1:0] mask,
                                                     alias_e sel,
                                                     logic [DATA_W-1:0] impl);
    logic [DATA_W-1:0] nxt;
    case (sel)
      ALIAS_SET: nxt = cur | mask;
      ALIAS_CLR: nxt = cur & ~mask;
      ALIAS_TOG: nxt = cur ^ mask;
      default:   nxt = mask;
    endcase
    return nxt & impl;
  endfunction

  // Mask covering the bits used by ndom domains.
  function automatic logic [DATA_W-1:0] impl_mask(int unsigned ndom);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < DATA_W; b++)
      if (b < 2 * ndom) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cgate_decode.sv
module cgate_decode
  import cgate_pkg::*;
#(
  parameter int unsigned NUM_GATES = 12,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                 wr,
  input  logic [IDX_W+3:0]     addr,
  output logic [NUM_GATES-1:0] hit,
  output alias_e               alias_sel,
  output logic [IDX_W-1:0]     idx,
  output logic                 idx_ok
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_GATES);

  logic unused_offset;
  assign unused_offset = ^addr[1:0];

  assign idx       = addr[IDX_W+3:4];
  assign alias_sel = alias_e'(addr[3:2]);
  assign idx_ok    = ({1'b0, idx} < LIMIT);

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_hit
    assign hit[g] = wr && idx_ok && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/cgate_reg.sv
module cgate_reg
  import cgate_pkg::*;
#(
  parameter int unsigned NUM_DOMAINS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  alias_e            alias_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_DOMAINS);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (wr_hit) q <= alias_update(q, wdata, alias_sel, IMPL);
  end

  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && alias_sel == ALIAS_SET) |=> (($past(q) & ~q) == '0)); // R3
  AST_CLR_ADDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && alias_sel == ALIAS_CLR) |=> ((q & ~$past(q)) == '0)); // R4
  AST_TOG_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && alias_sel == ALIAS_TOG && (wdata & IMPL) != '0) |=> (q != $past(q))); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & ~IMPL) == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q)); // R10
endmodule

// File: rtl/cgate_eval.sv
module cgate_eval
  import cgate_pkg::*;
#(
  parameter int unsigned NUM_DOMAINS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2*NUM_DOMAINS-1:0] cfg,
  input  logic [1:0]               mode,
  input  logic [NUM_DOMAINS-1:0]   dom_active,
  output logic                     gate_q
);
  logic [NUM_DOMAINS-1:0] permit;
  logic                   gate_d;
  logic                   any_always;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    assign permit[d] = dom_active[d] && need_met(cfg[2*d +: 2], mode);
  end

  assign gate_d = |permit;

  always_comb begin
    any_always = 1'b0;
    for (int d = 0; d < NUM_DOMAINS; d++)
      if (dom_active[d] && cfg[2*d +: 2] == NEED_ALWAYS) any_always = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_d;
  end

  AST_NO_NEED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0) |=> !gate_q); // R9
  AST_STOP_ONLY_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !any_always) |=> !gate_q); // R8
  AST_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    any_always |=> gate_q); // R8
  AST_IDLE_DOMAINS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_active == '0) |=> !gate_q); // R9
endmodule

// File: rtl/cgate_bank.sv
module cgate_bank
  import cgate_pkg::*;
#(
  parameter int unsigned NUM_GATES   = 12,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned NUM_DOMAINS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [IDX_W+3:0]       bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [1:0]             pwr_mode,
  input  logic [NUM_DOMAINS-1:0] dom_active,
  output logic [NUM_GATES-1:0]   gate_en
);
  localparam int unsigned CFG_W = 2 * NUM_DOMAINS;

  logic [NUM_GATES-1:0]        hit;
  alias_e                      alias_sel;
  logic [IDX_W-1:0]            idx;
  logic                        idx_ok;
  logic [DATA_W-1:0]           regs [NUM_GATES];
  logic [NUM_GATES*DATA_W-1:0] regs_flat;

  cgate_decode #(.NUM_GATES(NUM_GATES), .IDX_W(IDX_W)) u_decode (
    .wr(bus_wr), .addr(bus_addr), .hit(hit),
    .alias_sel(alias_sel), .idx(idx), .idx_ok(idx_ok)
  );

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    cgate_reg #(.NUM_DOMAINS(NUM_DOMAINS)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_hit(hit[g]), .alias_sel(alias_sel),
      .wdata(bus_wdata), .q(regs[g])
    );
    cgate_eval #(.NUM_DOMAINS(NUM_DOMAINS)) u_eval (
      .clk(clk), .rst_n(rst_n), .cfg(regs[g][CFG_W-1:0]), .mode(pwr_mode),
      .dom_active(dom_active), .gate_q(gate_en[g])
    );
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NUM_GATES; g++)
      if (idx_ok && idx == IDX_W'(g)) bus_rdata = regs[g];
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R6
  AST_OOR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !idx_ok) |=> $stable(regs_flat)); // R6
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |-> (bus_rdata == '0)); // R6
  AST_RESET_GATES_OFF: assert property (@(posedge clk)
    $past(!rst_n) |-> (gate_en == '0)); // R1
endmodule

// File: tb/cgate_bank_bench.sv
`timescale 1ns/1ps
module cgate_bank_bench;
  localparam int NG = 5;
  localparam int IW = 3;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [IW+3:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [1:0]    pwr_mode = 2'd0;
  logic [ND-1:0] dom_active = '0;
  logic [NG-1:0] gate_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [NG];
  int unsigned seed_val;

  always #4 clk = ~clk;

  cgate_bank #(.NUM_GATES(NG), .IDX_W(IW), .NUM_DOMAINS(ND)) u_cgate_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_mode(pwr_mode),
    .dom_active(dom_active), .gate_en(gate_en)
  );

  function automatic logic [IW+3:0] mk_addr(int gi, int al);
    return {IW'(gi), 2'(al), 2'($urandom_range(0, 3))};
  endfunction

  function automatic bit covers(logic [1:0] lvl, logic [1:0] m);
    if (lvl == 2'b11) return 1;
    if (lvl == 2'b10) return (m == 2'd0 || m == 2'd1);
    if (lvl == 2'b01) return (m == 2'd0);
    return 0;
  endfunction

  function automatic logic [NG-1:0] exp_gates();
    logic [NG-1:0] v = '0;
    for (int g = 0; g < NG; g++)
      for (int d = 0; d < ND; d++)
        if (dom_active[d] && covers(model[g][2*d +: 2], pwr_mode)) v[g] = 1'b1;
    return v;
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [IW+3:0] a, logic [31:0] d);
    int gi;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    gi = int'(a[IW+3:4]);
    if (gi < NG) begin
      case (a[3:2])
        2'd1: model[gi] = model[gi] | d;
        2'd2: model[gi] = model[gi] & ~d;
        2'd3: model[gi] = model[gi] ^ d;
        default: model[gi] = d;
      endcase
      model[gi] &= 32'h0000_00FF;
    end
  endtask

  task automatic check_read(string req, int gi, int al);
    logic [31:0] e;
    bus_addr = mk_addr(gi, al);
    #1;
    e = (gi < NG) ? model[gi] : 32'h0;
    check32(req, bus_rdata, e);
  endtask

  task automatic check_gates(string req);
    @(negedge clk);
    check32(req, 32'(gate_en), 32'(exp_gates()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    seed_val = $urandom(32'd1234);
    for (int g = 0; g < NG; g++) model[g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    dom_active = '1;
    @(negedge clk);
    // R1: reset state
    for (int g = 0; g < NG; g++) check_read("R1", g, 0);
    check32("R1 gates", 32'(gate_en), 32'h0);

    // R2 / R7: direct write keeps only implemented bits, readable via each alias
    bus_write(mk_addr(0, 0), 32'hFFFF_FFFF);
    for (int al = 0; al < 4; al++) check_read("R2 R7", 0, al);
    check32("R7 reserved", bus_rdata & 32'hFFFF_FF00, 32'h0);

    // R3: set alias keeps other bits
    bus_write(mk_addr(1, 0), 32'h0000_0021);
    bus_write(mk_addr(1, 1), 32'h0000_0003);
    check_read("R3", 1, 0);
    // R4: clear alias
    bus_write(mk_addr(1, 2), 32'h0000_0022);
    check_read("R4", 1, 2);
    // R5: toggle alias
    bus_write(mk_addr(1, 3), 32'h8000_00F0);
    check_read("R5", 1, 3);

    // R6: out-of-range writes ignored, reads return zero
    bus_write(mk_addr(5, 0), 32'hFFFF_FFFF);
    bus_write(mk_addr(7, 1), 32'h0000_00FF);
    for (int g = 0; g < NG; g++) check_read("R6 untouched", g, 0);
    check_read("R6 read zero", 6, 0);

    // R10: a gate change lags the register write by one edge
    bus_write(mk_addr(2, 0), 32'h0);
    @(negedge clk);
    pwr_mode = 2'd0; dom_active = 4'b0001;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = mk_addr(2, 0); bus_wdata = 32'h3;
    @(negedge clk);
    bus_wr = 1'b0; model[2] = 32'h3;
    check32("R10 lag", 32'(gate_en[2]), 32'h0);
    @(negedge clk);
    check32("R10 follow", 32'(gate_en[2]), 32'h1);

    // R8: each need level against every mode on domain 0 of gate 3
    for (int lvl = 0; lvl < 4; lvl++) begin
      bus_write(mk_addr(3, 0), 32'(lvl));
      for (int m = 0; m < 4; m++) begin
        pwr_mode = 2'(m);
        @(negedge clk);
        check_gates("R8");
      end
    end

    // R9: level present but its domain idle; another domain active
    bus_write(mk_addr(4, 0), 32'h0000_0030);
    pwr_mode = 2'd2; dom_active = 4'b0100;
    check_gates("R9");
    dom_active = 4'b1011;
    check_gates("R9");

    // Random mix across all aliases, modes and domain patterns
    for (int i = 0; i < 400; i++) begin
      bus_write(mk_addr($urandom_range(0, 7), $urandom_range(0, 3)), $urandom());
      pwr_mode = 2'($urandom_range(0, 3));
      dom_active = ND'($urandom());
      check_read("R2 R3 R4 R5 R6 R7 random", $urandom_range(0, 7), $urandom_range(0, 3));
      check_gates("R8 R9 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule